// File: doc/BRIEF.md
# Programmable Watchdog Timer Peripheral

This block is a watchdog timer that software reaches over a small register bus with a write strobe, a word address, write data and registered read data. Software programs a timeout period and turns counting on. It must then write the service register regularly to keep the system alive. The elapsed count advances only on a slow counter-clock enable. Each timeout interval is a programmable number of prescaled periods long.

When an interval runs out without service, the block raises an interrupt flag. If the next interval also runs out without service, it raises a system reset request. The reset request holds until the block's own synchronous reset is applied.

The enable, period and count-clear writes reach the timing logic only after a fixed settling delay. That delay is a number of bus cycles followed by a number of counter-clock ticks. A service write acts at once.

Top module: `wdog_periph`

## Requirements
- R1: After `rst_i`, every register reads zero and both `irq_o` and `sys_rst_req_o` are low.
- R2: Bit 0 of the control word (byte offset 0x0) enables counting. While the applied value of that bit is 0, the elapsed count holds.
- R3: The period field occupies bits 31:20 of the word at offset 0x4. Write data in bits 19:0 is dropped, and those bits always read back as 0.
- R4: The elapsed count (offset 0x8) advances by one only on a cycle where `tick_i` is high and counting is enabled. After (period+1)·2^PRESCALE_LOG2 such ticks the interval ends and the count restarts from zero.
- R5: The first interval that ends unserviced sets the interrupt flag. The flag drives `irq_o` and reads in bit 0 of offset 0xC. A second interval that ends while the flag is still set raises `sys_rst_req_o`.
- R6: Writing 1 in bit 0 to offset 0xC clears the count and the interrupt flag at the edge that accepts the write. Writing 0 there changes nothing.
- R7: A write to offset 0x8 clears the count once the settling delay has passed. The written data is not loaded.
- R8: A write to offset 0x0, 0x4 or 0x8 takes effect after BUS_LAT bus cycles, followed by TICK_LAT cycles with `tick_i` high. With the defaults and `tick_i` held high, a new enable is in force 15 edges after the write edge.
- R9: While such a write is waiting, a read of that offset returns the written value after masking. A second write during the wait replaces the value and starts the delay again.
- R10: `sys_rst_req_o` stays high until `rst_i` is asserted; a service write does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Counter-clock enable, one bus cycle per tick |
| bus_we_i | input | 1 | Write strobe |
| bus_addr_i | input | ADDR_W | Byte address; bits 3:2 select the register |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Registered read data for the address of the previous cycle |
| irq_o | output | 1 | Interrupt flag: first unserviced interval ended |
| sys_rst_req_o | output | 1 | System reset request, sticky until `rst_i` |

## Verification
A wrong settling counter shows up as the elapsed count starting, stopping or clearing a few edges early or late. A read of offset 0x8 sampled on every cycle reveals this with single-edge resolution. A wrong terminal compare or a wrong overflow stage shows up on `irq_o` or `sys_rst_req_o` exactly one interval after a service write, so the fault is visible within at most two intervals. A stale pending shadow shows up on the very next read of the register that was written.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Register select taken from byte address bits 3:2.
  // The order matters: indices 0..2 are the delayed registers.
  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_PERIOD = 2'd1,
    REG_COUNT  = 2'd2,
    REG_SVC    = 2'd3
  } wdog_reg_e;

  localparam int NUM_DELAYED = 3;

endpackage

// File: rtl/wdog_wsync.sv
// Holds one delayed register: shadow value, settle counters, applied copy.
module wdog_wsync #(
  parameter int DW       = 32,
  parameter int BUS_LAT  = 6,
  parameter int TICK_LAT = 9
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          tick_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          pend_o,
  output logic [DW-1:0] shadow_o,
  output logic [DW-1:0] cur_o,
  output logic          apply_o
);

  localparam int BW = (BUS_LAT  > 0) ? $clog2(BUS_LAT + 1)  : 1;
  localparam int TW = (TICK_LAT > 1) ? $clog2(TICK_LAT + 1) : 1;

  logic [BW-1:0] bus_cnt;
  logic [TW-1:0] tick_cnt;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pend_o   <= 1'b0;
      shadow_o <= '0;
      cur_o    <= '0;
      apply_o  <= 1'b0;
      bus_cnt  <= '0;
      tick_cnt <= '0;
    end else begin
      apply_o <= 1'b0;
      if (wr_i) begin
        // a fresh write replaces the value and restarts the settle window
        pend_o   <= 1'b1;
        shadow_o <= wdata_i;
        bus_cnt  <= '0;
        tick_cnt <= '0;
      end else if (pend_o) begin
        if (bus_cnt != BW'(BUS_LAT)) begin
          bus_cnt <= bus_cnt + 1'b1;
        end else if (tick_i) begin
          if (tick_cnt == TW'(TICK_LAT - 1)) begin
            pend_o  <= 1'b0;
            cur_o   <= shadow_o;
            apply_o <= 1'b1;
          end else begin
            tick_cnt <= tick_cnt + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/wdog_count.sv
// Elapsed counter with two-stage overflow escalation.
module wdog_count #(
  parameter int PW  = 12,
  parameter int PRE = 20,
  localparam int CW = PW + PRE
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          tick_i,
  input  logic          en_i,
  input  logic [PW-1:0] period_i,
  input  logic          svc_i,
  input  logic          reinit_i,
  output logic [CW-1:0] cnt_o,
  output logic          irq_o,
  output logic          rst_req_o
);

  // (period+1)*2^PRE - 1 written as a concatenation, no adder needed
  logic [CW-1:0] terminal;
  assign terminal = {period_i, {PRE{1'b1}}};

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_o     <= '0;
      irq_o     <= 1'b0;
      rst_req_o <= 1'b0;
    end else if (svc_i) begin
      cnt_o <= '0;
      irq_o <= 1'b0;
    end else if (reinit_i) begin
      cnt_o <= '0;
    end else if (en_i && tick_i) begin
      if (cnt_o == terminal) begin
        cnt_o <= '0;
        if (irq_o) rst_req_o <= 1'b1;
        else       irq_o     <= 1'b1;
      end else begin
        cnt_o <= cnt_o + 1'b1;
      end
    end
  end

endmodule

// File: rtl/wdog_periph.sv
module wdog_periph
  import wdog_pkg::*;
#(
  parameter int ADDR_W        = 4,
  parameter int DATA_W        = 32,
  parameter int PERIOD_W      = 12,
  parameter int PRESCALE_LOG2 = 20,
  parameter int BUS_LAT       = 6,
  parameter int TICK_LAT      = 9
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              tick_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic              sys_rst_req_o
);

  localparam int CW    = PERIOD_W + PRESCALE_LOG2;
  localparam int P_LSB = DATA_W - PERIOD_W;

  wdog_reg_e reg_sel;
  assign reg_sel = wdog_reg_e'(bus_addr_i[3:2]);

  logic [DATA_W-1:0] wmask  [NUM_DELAYED];
  logic [DATA_W-1:0] shadow [NUM_DELAYED];
  logic [DATA_W-1:0] cur    [NUM_DELAYED];
  logic              pend   [NUM_DELAYED];
  logic              apply  [NUM_DELAYED];

  always_comb begin
    wmask[REG_CTRL]   = DATA_W'(1);
    wmask[REG_PERIOD] = {{PERIOD_W{1'b1}}, {P_LSB{1'b0}}};
    wmask[REG_COUNT]  = '1;
  end

  for (genvar g = 0; g < NUM_DELAYED; g++) begin : g_sync
    wdog_wsync #(
      .DW(DATA_W), .BUS_LAT(BUS_LAT), .TICK_LAT(TICK_LAT)
    ) u_sync (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .tick_i   (tick_i),
      .wr_i     (bus_we_i && (reg_sel == wdog_reg_e'(g))),
      .wdata_i  (bus_wdata_i & wmask[g]),
      .pend_o   (pend[g]),
      .shadow_o (shadow[g]),
      .cur_o    (cur[g]),
      .apply_o  (apply[g])
    );
  end

  logic          svc;
  logic [CW-1:0] cnt;

  assign svc = bus_we_i && (reg_sel == REG_SVC) && bus_wdata_i[0];

  wdog_count #(.PW(PERIOD_W), .PRE(PRESCALE_LOG2)) u_count (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .tick_i    (tick_i),
    .en_i      (cur[REG_CTRL][0]),
    .period_i  (cur[REG_PERIOD][DATA_W-1:P_LSB]),
    .svc_i     (svc),
    .reinit_i  (apply[REG_COUNT]),
    .cnt_o     (cnt),
    .irq_o     (irq_o),
    .rst_req_o (sys_rst_req_o)
  );

  logic [DATA_W-1:0] rd_next;
  always_comb begin
    unique case (reg_sel)
      REG_CTRL:   rd_next = shadow[REG_CTRL];
      REG_PERIOD: rd_next = shadow[REG_PERIOD];
      REG_COUNT:  rd_next = pend[REG_COUNT] ? shadow[REG_COUNT] : DATA_W'(cnt);
      default:    rd_next = DATA_W'(irq_o);
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) bus_rdata_o <= '0;
    else       bus_rdata_o <= rd_next;
  end

  logic unused_bits;
  assign unused_bits = ^{bus_addr_i, cur[REG_CTRL][DATA_W-1:1], cur[REG_COUNT],
                         cur[REG_PERIOD][P_LSB-1:0], apply[REG_CTRL],
                         apply[REG_PERIOD], pend[REG_CTRL], pend[REG_PERIOD]};

endmodule

// File: rtl/wdog_periph_chk.sv
module wdog_periph_chk #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int PERIOD_W = 12
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              tick_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic              irq_o,
  input logic              sys_rst_req_o
);

  p_low_bits_zero_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (bus_addr_i[3:2] == 2'd1) |=> (bus_rdata_o[DATA_W-PERIOD_W-1:0] == '0));

  p_quiet_no_tick_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (!tick_i && !bus_we_i) |=> ($stable(irq_o) && $stable(sys_rst_req_o)));

  p_irq_first_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(sys_rst_req_o) |-> $past(irq_o));

  p_service_clears_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (bus_we_i && bus_addr_i[3:2] == 2'd3 && bus_wdata_i[0]) |=> !irq_o);

  p_reset_sticky_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    sys_rst_req_o |=> sys_rst_req_o);

endmodule

bind wdog_periph wdog_periph_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PERIOD_W(PERIOD_W)
) u_chk (.*);

// File: tb/tb_wdog_periph.sv
module tb_wdog_periph;

  localparam logic [3:0] A_CTRL = 4'h0, A_PER = 4'h4, A_CNT = 4'h8, A_SVC = 4'hC;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b1;
  logic        we = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, sreq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  int          due_q [$];
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  wdog_periph #(
    .ADDR_W(4), .DATA_W(32), .PERIOD_W(12), .PRESCALE_LOG2(2),
    .BUS_LAT(6), .TICK_LAT(9)
  ) dut (
    .clk_i(clk), .rst_i(rst), .tick_i(tick), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .sys_rst_req_o(sreq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // scoreboard monitor: compare read data in the cycle it was promised
  always @(posedge clk) begin
    #2;
    while (due_q.size() > 0 && due_q[0] == cyc) begin
      chk(rdata, exp_q[0], tag_q[0]);
      void'(due_q.pop_front());
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
    addr = a;
    due_q.push_back(cyc + 1);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
  endtask

  task automatic run_tests();
    logic [31:0] e;
    rst = 1'b1;
    step(3);
    rst = 1'b0;
    // R1 reset state
    chk({31'b0, irq}, 0, "R1 irq");
    chk({31'b0, sreq}, 0, "R1 sysreq");
    rd(A_CTRL, 0, "R1 ctrl"); rd(A_PER, 0, "R1 period");
    rd(A_CNT, 0, "R1 count"); rd(A_SVC, 0, "R1 svc");

    // R3 and R9: masking and pending readback
    wr(A_PER, 32'hFFFF_FFFF);
    rd(A_PER, 32'hFFF0_0000, "R3 mask");
    wr(A_PER, 32'h0071_2345);
    rd(A_PER, 32'h0070_0000, "R9 replace pending");
    step(20);
    rd(A_PER, 32'h0070_0000, "R3 applied");

    // R8 and R2: enable settles after 15 edges
    wr(A_CTRL, 32'h1);
    for (int k = 1; k <= 24; k++) begin
      e = (k > 16) ? 32'(k - 16) : 32'd0;
      rd(A_CNT, e, "R8 enable latency");
    end
    rd(A_CTRL, 1, "R2 ctrl read");

    // R6 service clears count at once
    wr(A_SVC, 1);
    for (int k = 1; k <= 3; k++) rd(A_CNT, 32'(k - 1), "R6 service clears");

    // R7 count clear, R9 pending value shown during the wait
    wr(A_SVC, 1);
    wr(A_CNT, 32'h0000_0000);
    for (int k = 1; k <= 20; k++) begin
      if (k < 16)       e = 0;
      else if (k == 16) e = 16;
      else              e = 32'(k - 17);
      rd(A_CNT, e, "R7 count clear");
    end

    // R2 disable holds the count
    wr(A_SVC, 1);
    wr(A_CTRL, 0);
    step(25);
    rd(A_CNT, 16, "R2 hold");
    step(5);
    rd(A_CNT, 16, "R2 hold later");

    // R4 counting only on ticks
    wr(A_CTRL, 1);
    step(20);
    tick = 1'b0;
    wr(A_SVC, 1);
    step(10);
    rd(A_CNT, 0, "R4 no tick");
    for (int k = 0; k < 3; k++) begin
      tick = 1'b1; step(1); tick = 1'b0; step(2);
    end
    rd(A_CNT, 3, "R4 three ticks");
    tick = 1'b1;

    // R9 second write restarts the delay
    wr(A_CTRL, 0);
    step(20);
    wr(A_SVC, 1);
    wr(A_CTRL, 1);
    step(2);
    wr(A_CTRL, 1);
    step(20);
    rd(A_CNT, 5, "R9 restart delay");

    // R4 and R5: period 1 gives 8-tick intervals
    wr(A_PER, 32'h0010_0000);
    step(20);
    wr(A_SVC, 1);
    step(7);
    chk({31'b0, irq}, 0, "R4 before end");
    step(1);
    chk({31'b0, irq}, 1, "R5 first overflow");
    rd(A_SVC, 1, "R5 irq read");
    step(6);
    chk({31'b0, sreq}, 0, "R5 before second");
    step(1);
    chk({31'b0, sreq}, 1, "R5 second overflow");

    // R10 sticky reset request
    wr(A_SVC, 1);
    chk({31'b0, irq}, 0, "R6 irq cleared");
    step(20);
    chk({31'b0, sreq}, 1, "R10 sticky");
    rst = 1'b1;
    step(2);
    rst = 1'b0;
    chk({31'b0, sreq}, 0, "R10 cleared by reset");
    rd(A_CTRL, 0, "R1 ctrl after reset");

    // R6 regular service keeps the system alive
    wr(A_PER, 32'h0010_0000);
    wr(A_CTRL, 1);
    step(20);
    wr(A_SVC, 1);
    for (int k = 0; k < 6; k++) begin
      step(5);
      wr(A_SVC, 1);
    end
    chk({31'b0, irq}, 0, "R6 kept alive irq");
    chk({31'b0, sreq}, 0, "R6 kept alive sysreq");

    // R5 service between overflows restarts escalation
    wr(A_SVC, 1);
    step(9);
    chk({31'b0, irq}, 1, "R5 irq again");
    wr(A_SVC, 1);
    chk({31'b0, irq}, 0, "R6 service after irq");
    step(8);
    chk({31'b0, irq}, 1, "R5 first after service");
    chk({31'b0, sreq}, 0, "R5 not consecutive");

    // R6 writing zero to service has no effect
    wr(A_SVC, 0);
    chk({31'b0, irq}, 1, "R6 zero write");
    rd(A_SVC, 1, "R6 zero write read");
    step(3);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule